// File: doc/BRIEF.md
# Factory-Restore Erase Sequencer

This block guards and runs the sequence that returns a device to its blank factory state. Software writes three 32-bit unlock words through a small valid/ready word port. Each word is compared, in arrival order, against a fixed key. Only when all three match does the sequencer start. A wrong word throws away any progress made so far.

Once unlocked, the block works through six steps in a fixed order. The steps are: clear battery-backed RAM, clear system SRAM, open the flash protection registers, erase the EEPROM pages, mass-erase the flash, and write the boot configuration. Each step raises its own request line and holds it until the matching external engine returns a done pulse. After the last step the block clears the 24-bit completion-status field and emits a single-cycle system-reset pulse.

The word port follows valid/ready rules. A word is taken only on a cycle where `key_valid` and `key_ready` are both high. `key_ready` is low for the whole time the sequencer is busy, so a sender holding `key_valid` simply waits; nothing is lost or counted during that time. The request/done pairs and the status and reset pins are plain control signals.

Top module: `fact_restore_seq`

## Requirements
- R1: After reset, `step_req` is 0, `busy` is 0, `sys_reset` is 0, `key_ready` is 1, and `status_field` holds 0xFFFFFF.
- R2: A key word is consumed only on a clock edge where `key_valid` and `key_ready` are both 1. `key_ready` is 0 whenever `busy` is 1.
- R3: The consumed words must equal 0x02010100, then 0x0D080503, then 0x59372215. In the cycle after the third matching word is consumed, `step_req` equals 6'b000001 and `busy` is 1.
- R4: A consumed word that does not match the key expected at its position returns progress to the first position, without starting any step. The word after a mismatch is compared against the first key only.
- R5: `step_req` bit k is the request of step k. Bit 0 clears battery-backed RAM, bit 1 clears SRAM, bit 2 opens flash protection, bit 3 erases EEPROM, bit 4 mass-erases flash and bit 5 writes boot configuration. At most one bit is high at a time. A request stays high until `step_done` bit k is seen at a clock edge. For k<5, bit k+1 is then high from the next cycle.
- R6: While step k is requested, `step_done` bits other than bit k have no effect.
- R7: `prot_wr_en` is high exactly while step 2 is requested, with `prot_wr_data` = 0xFFFFFFFF. Step 4 is never requested before step 2 has completed in the same run.
- R8: `boot_wr_en` is high exactly while step 5 is requested, with `boot_wr_data` = 0xFFFFFFFE.
- R9: In the cycle after step 5's done is seen, `step_req` is 0, `status_field` is 0x000000 and `sys_reset` is 1. `sys_reset` is 1 for exactly one cycle. `status_field` keeps 0 until the next reset.
- R10: `busy` is 1 from the first step request through the `sys_reset` cycle, and 0 in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| key_valid | input | 1 | Unlock word present |
| key_ready | output | 1 | Sequencer can take a word |
| key_data | input | 32 | Unlock word |
| step_req | output | 6 | One request per step, bit order is step order |
| step_done | input | 6 | One done pulse per step from the engines |
| prot_wr_en | output | 1 | Write strobe for flash protection registers |
| prot_wr_data | output | 32 | Value for flash protection registers |
| boot_wr_en | output | 1 | Write strobe for boot configuration |
| boot_wr_data | output | 32 | Value for boot configuration |
| status_field | output | 24 | Completion-status field |
| busy | output | 1 | Sequence in progress |
| sys_reset | output | 1 | Single-cycle system-reset pulse |

## Verification
The bench flips every bit of every key position in turn, so that all 96 near-miss words are tried. A comparator that ignores a bit, or that accepts words out of position, would start the erase chain on one of them. It also sends the first key twice and then the remaining keys. A checker that kept partial progress, or reused the mismatching word as a new first word, would unlock on that pattern. The chain runs several times with varied engine latencies and with wrong-step done pulses injected. A sequencer that advances on any done bit, skips or reorders a step, drops a request early, or lets the reset pulse linger or arrive without clearing the status field would be caught at the cycle-exact checks.

// File: rtl/frs_pkg.sv
package frs_pkg;
  localparam int WORD_W    = 32;
  localparam int NUM_KEYS  = 3;
  localparam int NUM_STEPS = 6;
  localparam int STAT_W    = 24;

  // step positions whose order is behaviour
  localparam int STEP_PROT  = 2;
  localparam int STEP_FLASH = 4;
  localparam int STEP_BOOT  = 5;

  localparam logic [WORD_W-1:0] PROT_OPEN    = 32'hFFFF_FFFF;
  localparam logic [WORD_W-1:0] BOOT_DEFAULT = 32'hFFFF_FFFE;
  localparam logic [STAT_W-1:0] STAT_PENDING = '1;
  localparam logic [STAT_W-1:0] STAT_CLEARED = '0;

  function automatic logic [WORD_W-1:0] unlock_key(input int pos);
    case (pos)
      0:       unlock_key = 32'h0201_0100;
      1:       unlock_key = 32'h0D08_0503;
      default: unlock_key = 32'h5937_2215;
    endcase
  endfunction

  typedef enum logic [1:0] {SQ_IDLE, SQ_RUN, SQ_FIN} seq_state_t;
endpackage

// File: rtl/frs_key_check.sv
module frs_key_check
  import frs_pkg::*;
#(
  parameter int N_KEYS = NUM_KEYS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [WORD_W-1:0] word,
  output logic              unlock
);
  localparam int KIDX_W = (N_KEYS > 1) ? $clog2(N_KEYS) : 1;
  localparam logic [KIDX_W-1:0] LAST_POS = KIDX_W'(N_KEYS - 1);

  logic [KIDX_W-1:0] pos_q;
  logic [N_KEYS-1:0] hit_vec;
  logic              match;

  for (genvar g = 0; g < N_KEYS; g++) begin : g_cmp
    assign hit_vec[g] = (pos_q == KIDX_W'(g)) && (word == unlock_key(g));
  end

  assign match  = |hit_vec;
  assign unlock = accept && match && (pos_q == LAST_POS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pos_q <= '0;
    else if (accept) begin
      if (match && pos_q != LAST_POS) pos_q <= pos_q + 1'b1;
      else                            pos_q <= '0;
    end
  end

  // R4
  no_partial_after_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !match) |=> (pos_q == '0));
endmodule

// File: rtl/frs_step_seq.sv
module frs_step_seq
  import frs_pkg::*;
#(
  parameter int N_STEPS = NUM_STEPS,
  parameter int ST_W    = STAT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [N_STEPS-1:0] step_done,
  output logic [N_STEPS-1:0] step_req,
  output logic               busy,
  output logic               sys_reset,
  output logic [ST_W-1:0]    status_field
);
  localparam int IDX_W = $clog2(N_STEPS);
  localparam logic [IDX_W-1:0] LAST_STEP = IDX_W'(N_STEPS - 1);

  seq_state_t       state_q;
  logic [IDX_W-1:0] cur_q;
  logic [ST_W-1:0]  stat_q;
  logic             cur_done;

  assign cur_done = step_done[cur_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      cur_q   <= '0;
      stat_q  <= ST_W'(STAT_PENDING);
    end else begin
      case (state_q)
        SQ_IDLE: if (start) begin
          state_q <= SQ_RUN;
          cur_q   <= '0;
        end
        SQ_RUN: if (cur_done) begin
          if (cur_q == LAST_STEP) begin
            state_q <= SQ_FIN;
            stat_q  <= ST_W'(STAT_CLEARED);
          end else begin
            cur_q <= cur_q + 1'b1;
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < N_STEPS; g++) begin : g_req
    assign step_req[g] = (state_q == SQ_RUN) && (cur_q == IDX_W'(g));
  end

  assign busy         = (state_q != SQ_IDLE);
  assign sys_reset    = (state_q == SQ_FIN);
  assign status_field = stat_q;

  // R5
  one_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(step_req));
  // R5
  request_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((step_req != '0) && ((step_req & step_done) == '0)) |=> (step_req == $past(step_req)));
  // R9
  reset_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset |=> !sys_reset);
  // R9
  status_on_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset |-> (status_field == '0));
  // R10
  busy_on_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset |-> busy);
endmodule

// File: rtl/frs_cfg_write.sv
module frs_cfg_write
  import frs_pkg::*;
#(
  parameter int N_STEPS = NUM_STEPS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_STEPS-1:0] step_req,
  output logic               prot_wr_en,
  output logic [WORD_W-1:0]  prot_wr_data,
  output logic               boot_wr_en,
  output logic [WORD_W-1:0]  boot_wr_data
);
  assign prot_wr_en   = step_req[STEP_PROT];
  assign prot_wr_data = PROT_OPEN;
  assign boot_wr_en   = step_req[STEP_BOOT];
  assign boot_wr_data = BOOT_DEFAULT;

  logic prot_seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           prot_seen_q <= 1'b0;
    else if (step_req[0]) prot_seen_q <= 1'b0;
    else if (prot_wr_en)  prot_seen_q <= 1'b1;
  end

  // R7
  open_before_erase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_req[STEP_FLASH] |-> prot_seen_q);
endmodule

// File: rtl/fact_restore_seq.sv
module fact_restore_seq
  import frs_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 key_valid,
  output logic                 key_ready,
  input  logic [WORD_W-1:0]    key_data,
  output logic [NUM_STEPS-1:0] step_req,
  input  logic [NUM_STEPS-1:0] step_done,
  output logic                 prot_wr_en,
  output logic [WORD_W-1:0]    prot_wr_data,
  output logic                 boot_wr_en,
  output logic [WORD_W-1:0]    boot_wr_data,
  output logic [STAT_W-1:0]    status_field,
  output logic                 busy,
  output logic                 sys_reset
);
  logic accept;
  logic unlock;

  assign key_ready = !busy;
  assign accept    = key_valid && key_ready;

  frs_key_check #(.N_KEYS(NUM_KEYS)) u_key (
    .clk(clk), .rst_n(rst_n), .accept(accept), .word(key_data), .unlock(unlock)
  );

  frs_step_seq #(.N_STEPS(NUM_STEPS), .ST_W(STAT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(unlock), .step_done(step_done),
    .step_req(step_req), .busy(busy), .sys_reset(sys_reset),
    .status_field(status_field)
  );

  frs_cfg_write #(.N_STEPS(NUM_STEPS)) u_cfg (
    .clk(clk), .rst_n(rst_n), .step_req(step_req),
    .prot_wr_en(prot_wr_en), .prot_wr_data(prot_wr_data),
    .boot_wr_en(boot_wr_en), .boot_wr_data(boot_wr_data)
  );

  // R2
  no_take_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !key_ready);
  // R3
  unlock_starts_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unlock |=> (step_req == NUM_STEPS'(1)));
endmodule

// File: tb/fact_restore_seq_test.sv
module fact_restore_seq_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        key_valid = 0;
  logic        key_ready;
  logic [31:0] key_data = '0;
  logic [5:0]  step_req;
  logic [5:0]  step_done = '0;
  logic        prot_wr_en, boot_wr_en, busy, sys_reset;
  logic [31:0] prot_wr_data, boot_wr_data;
  logic [23:0] status_field;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  fact_restore_seq uut (.*);

  function automatic logic [31:0] kw(input int p);
    return (p == 0) ? 32'h0201_0100 : (p == 1) ? 32'h0D08_0503 : 32'h5937_2215;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] w);
    key_valid = 1; key_data = w;
    @(negedge clk);
    key_valid = 0;
  endtask

  task automatic idle_check(input string tag);
    @(negedge clk);
    chk(step_req == 0 && !busy && key_ready, tag, {25'd0, busy, step_req}, 32'h0);
  endtask

  task automatic run_chain(input int r, input bit hold_key);
    send(kw(0)); send(kw(1));
    key_valid = 1; key_data = kw(2);
    @(negedge clk);
    key_valid = hold_key; key_data = kw(0);
    chk(step_req == 6'b1 && busy, "R3 start", {26'd0, step_req}, 32'h1);
    chk(!key_ready, "R2 ready low when busy", {31'd0, key_ready}, 0);
    for (int k = 0; k < 6; k++) begin
      int lat = (k + r) % 4;
      chk(step_req == 6'(1 << k), "R5 order", {26'd0, step_req}, 32'(1 << k));
      chk(prot_wr_en == (k == 2) && prot_wr_data == 32'hFFFF_FFFF, "R7 prot write",
          prot_wr_data, 32'hFFFF_FFFF);
      chk(boot_wr_en == (k == 5) && boot_wr_data == 32'hFFFF_FFFE, "R8 boot write",
          boot_wr_data, 32'hFFFF_FFFE);
      for (int w = 0; w < lat; w++) begin
        step_done = ~6'(1 << k);
        @(negedge clk);
        chk(step_req == 6'(1 << k) && busy, "R6 foreign done ignored", {26'd0, step_req}, 32'(1 << k));
      end
      step_done = 6'(1 << k);
      @(negedge clk);
      step_done = 0;
    end
    key_valid = 0;
    chk(step_req == 0 && sys_reset && busy, "R9 reset pulse", {29'd0, step_req == 0, sys_reset, busy}, 32'h7);
    chk(status_field == 24'h0, "R9 status cleared", {8'd0, status_field}, 0);
    @(negedge clk);
    chk(!sys_reset && !busy && key_ready, "R10 busy ends after pulse", {30'd0, sys_reset, busy}, 0);
    chk(status_field == 24'h0, "R9 status stays", {8'd0, status_field}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(step_req == 0 && !busy && !sys_reset && key_ready, "R1 reset outputs",
        {28'd0, step_req == 0, busy, sys_reset, key_ready}, 32'h9);
    chk(status_field == 24'hFFFFFF, "R1 status pending", {8'd0, status_field}, 32'hFFFFFF);

    // R4 sweep: every single-bit miss at each key position
    for (int p = 0; p < 3; p++) begin
      for (int b = 0; b < 32; b++) begin
        for (int q = 0; q < p; q++) send(kw(q));
        send(kw(p) ^ (32'h1 << b));
        idle_check("R4 near-miss word");
      end
    end

    // R4: repeated first key clears progress; the rest must not unlock
    send(kw(0)); send(kw(0)); send(kw(1)); send(kw(2));
    idle_check("R4 repeated first key");

    // R2: valid with no edge accepted beyond one word; partial prefix then miss
    send(kw(0)); send(kw(1)); send(32'h0);
    idle_check("R4 miss at last position");

    for (int r = 0; r < 4; r++) run_chain(r, r[0]);

    // R2: words held during the run were not counted; fresh miss still idles
    send(kw(1)); send(kw(2));
    idle_check("R2 no leftover progress");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule